// File: doc/BRIEF.md
# Pulse Width and Period Capture Timer

This block measures an external rectangular waveform in units of the internal clock. Two flip-flops synchronise the input, and a third register supplies the previous level for edge detection. A polarity input selects which transition counts as the leading edge. After it is enabled, the timer waits at a count of one until the first leading edge arrives. From then on it counts once per clock. On each trailing edge it copies the count into a width register. On each later leading edge it copies the count into a period register and restarts from one.

When software turns on the interrupt enable, a captured width is held while the interrupt flag is set. Period capture keeps going in every case. The counter stops at its all-ones value and raises a sticky overflow bit. A small register window exposes width, period, status and the running count for reading. The only write with any effect is the flag-clear write.

Top module: `pwcap_timer`

## Requirements
- R1: After reset, width and period read 0, status reads 0 and the count reads 1.
- R2: A level change on `sig_i` sampled at clock edge k is acted on at clock edge k+2. The input passes two synchroniser flops and one edge-history flop on the way.
- R3: While `enable_i` is low, the count is held at 1, the timer is disarmed and overflow is cleared. After enable, the count stays at 1 until the first leading edge.
- R4: Once armed, the count increases by exactly one on every clock without a leading edge.
- R5: On an armed trailing edge, the width register takes the count value held just before that edge, unless R9 applies.
- R6: On a leading edge while armed, the period register takes the count value and the count reloads to 1. The first leading edge after enable only arms the timer and captures no period.
- R7: With `pol_i` = 1 the rising edge is leading and the falling edge is trailing. With `pol_i` = 0 the roles swap, so the low time is measured.
- R8: The flag (status bit 0, also on `irq_o`) sets on every width capture. A write with `wdata_i[0]` = 1 to address 2 clears it. A capture in the same cycle as the clear wins.
- R9: While `irq_en_i` = 1 and the flag is set, trailing edges leave the width register unchanged. Leading edges still update the period register.
- R10: The count stops at all-ones and sets overflow (status bit 1). Overflow clears on the next leading-edge reload or when the timer is disabled.
- R11: Writes to address 0 (width), 1 (period) or 3 (count) have no effect. A write to address 2 with bit 0 = 0 has no effect.
- R12: The read address selects the data: 0 is width, 1 is period, 2 is status {overflow, flag} in bits 1:0, and 3 is the running count. `irq_o` always equals the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Timer enable |
| pol_i | input | 1 | 1: rising edge is leading; 0: falling edge is leading |
| irq_en_i | input | 1 | Interrupt enable, makes width sticky |
| sig_i | input | 1 | Asynchronous measured waveform |
| addr_i | input | 2 | Register select for read and write |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | CNT_W | Write data, bit 0 clears the flag at address 2 |
| rdata_o | output | CNT_W | Selected register value |
| irq_o | output | 1 | Interrupt flag |

## Verification
Two pairs of events can land in the same cycle. The first pair is a trailing-edge width capture and a software flag clear. The bench drives the falling input level and issues the clear write exactly two clocks later, so both reach the register on the same edge. The flag must then stay set. The second pair is saturation and a leading-edge reload. The bench holds the input past the all-ones count and then sends a new leading edge. Period must read all-ones and overflow must drop on that edge. A behavioural reference model runs alongside and judges both cases cycle by cycle.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;
  typedef enum logic [1:0] {
    REG_WIDTH  = 2'd0,
    REG_PERIOD = 2'd1,
    REG_STATUS = 2'd2,
    REG_COUNT  = 2'd3
  } reg_sel_e;

  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_OVF_BIT  = 1;
endpackage

// File: rtl/pwcap_edge.sv
module pwcap_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic pol_i,
  output logic lead_o,
  output logic trail_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sig_i};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise    = sync_q[LAST] & ~prev_q;
  assign fall    = ~sync_q[LAST] & prev_q;
  assign lead_o  = pol_i ? rise : fall;
  assign trail_o = pol_i ? fall : rise;
endmodule

// File: rtl/pwcap_counter.sv
module pwcap_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             lead_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             armed_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - CNT_ONE;

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= CNT_ONE;
      armed_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= CNT_ONE;
      armed_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (lead_i) begin
      cnt_q   <= CNT_ONE;
      armed_q <= 1'b1;
      ovf_q   <= 1'b0;
    end else if (armed_q && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_ONE;
      if (cnt_q == CNT_PRE) ovf_q <= 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;
  assign ovf_o   = ovf_q;

  assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_o == CNT_ONE && !armed_o && !ovf_o));
  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && armed_o && !lead_i && cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + CNT_ONE);
  assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lead_i) |=> (cnt_o == CNT_ONE && armed_o && !ovf_o));
  assert_saturate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && armed_o && !lead_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX && ovf_o));
endmodule

// File: rtl/pwcap_capture.sv
module pwcap_capture #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             lead_i,
  input  logic             trail_i,
  input  logic             armed_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             irq_en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] width_o,
  output logic [CNT_W-1:0] period_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] width_q, period_q;
  logic             flag_q;
  logic             cap_w, cap_p;

  // width is frozen while a flagged capture awaits software
  assign cap_w = en_i && trail_i && armed_i && !(irq_en_i && flag_q);
  assign cap_p = en_i && lead_i && armed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q  <= '0;
      period_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (cap_w) width_q <= cnt_i;
      if (cap_p) period_q <= cnt_i;
      if (cap_w)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign width_o  = width_q;
  assign period_o = period_q;
  assign flag_o   = flag_q;

  assert_width_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && trail_i && irq_en_i && flag_o) |=> $stable(width_o));
  assert_period_update_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lead_i && armed_i) |=> period_o == $past(cnt_i));
  assert_width_take_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && trail_i && armed_i && !irq_en_i) |=> (width_o == $past(cnt_i) && flag_o));
  assert_flag_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !trail_i) |=> !flag_o);
endmodule

// File: rtl/pwcap_timer.sv
module pwcap_timer
  import pwcap_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             pol_i,
  input  logic             irq_en_i,
  input  logic             sig_i,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  logic             lead, trail, armed, ovf, flag, clr;
  logic [CNT_W-1:0] cnt, width, period;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[CNT_W-1:1];
  assign clr = wr_i && (reg_sel_e'(addr_i) == REG_STATUS) && wdata_i[0];

  pwcap_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sig_i   (sig_i),
    .pol_i   (pol_i),
    .lead_o  (lead),
    .trail_o (trail)
  );

  pwcap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (enable_i),
    .lead_i  (lead),
    .cnt_o   (cnt),
    .armed_o (armed),
    .ovf_o   (ovf)
  );

  pwcap_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (enable_i),
    .lead_i   (lead),
    .trail_i  (trail),
    .armed_i  (armed),
    .cnt_i    (cnt),
    .irq_en_i (irq_en_i),
    .clr_i    (clr),
    .width_o  (width),
    .period_o (period),
    .flag_o   (flag)
  );

  always_comb begin
    rdata_o = '0;
    case (reg_sel_e'(addr_i))
      REG_WIDTH:  rdata_o = width;
      REG_PERIOD: rdata_o = period;
      REG_STATUS: begin
        rdata_o[STAT_FLAG_BIT] = flag;
        rdata_o[STAT_OVF_BIT]  = ovf;
      end
      default:    rdata_o = cnt;
    endcase
  end

  assign irq_o = flag;

  assert_ro_width_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trail) |=> $stable(width));
endmodule

// File: tb/sim_pwcap_timer.sv
module sim_pwcap_timer;
  localparam int W    = 8;
  localparam int MAXV = 255;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0, pol = 1'b1, irq_en = 1'b0, sig = 1'b0, wr = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         irq;

  int checks = 0, errors = 0, cyc = 0, rot = 0;
  bit done = 1'b0;

  int q[$];
  int m_cnt, m_w, m_p;
  bit m_armed, m_ovf, m_flag;

  always #2 clk = ~clk;

  pwcap_timer #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .pol_i(pol), .irq_en_i(irq_en),
    .sig_i(sig), .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // behavioural reference, advanced on each rising clock
  always @(posedge clk) begin
    if (!rst_n) begin
      q = '{0, 0, 0};
      m_cnt = 1; m_w = 0; m_p = 0; m_armed = 0; m_ovf = 0; m_flag = 0;
    end else begin
      bit s, p, rise, fall, lead, trail, clr, capw;
      int old;
      s = q[1] != 0; p = q[2] != 0;
      rise = s && !p; fall = !s && p;
      lead = pol ? rise : fall;
      trail = pol ? fall : rise;
      clr = wr && addr == 2'd2 && wdata[0];
      old = m_cnt;
      capw = enable && trail && m_armed && !(irq_en && m_flag);
      if (capw) m_w = old;
      if (capw) m_flag = 1;
      else if (clr) m_flag = 0;
      if (!enable) begin
        m_cnt = 1; m_armed = 0; m_ovf = 0;
      end else if (lead) begin
        if (m_armed) m_p = old;
        m_armed = 1; m_cnt = 1; m_ovf = 0;
      end else if (m_armed && m_cnt != MAXV) begin
        m_cnt++;
        if (m_cnt == MAXV) m_ovf = 1;
      end
      q.push_front(int'(sig));
      void'(q.pop_back());
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      case (addr)
        2'd0: chk(int'(rdata), m_w, "R5 R9 width");
        2'd1: chk(int'(rdata), m_p, "R6 R9 period");
        2'd2: chk(int'(rdata), (int'(m_ovf) << 1) | int'(m_flag), "R8 R10 status");
        default: chk(int'(rdata), m_cnt, "R2 R4 count");
      endcase
      chk(int'(irq), int'(m_flag), "R12 irq");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      finish_run();
    end
  end

  task automatic tick(input logic v);
    @(negedge clk);
    sig = v;
    addr = 2'(rot);
    rot++;
  endtask

  task automatic hold(input logic v, input int n);
    for (int i = 0; i < n; i++) tick(v);
  endtask

  task automatic pulse(input int a, input int b, input logic lvl);
    hold(lvl, a);
    hold(~lvl, b);
  endtask

  task automatic peek(input logic [1:0] a, input int exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(int'(rdata), exp, tag);
  endtask

  task automatic wr_reg(input logic [1:0] a, input int d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = W'(d);
    @(negedge clk);
    wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    peek(0, 0, "R1 width");
    peek(1, 0, "R1 period");
    peek(2, 0, "R1 status");
    peek(3, 1, "R1 count");

    @(negedge clk) enable = 1'b1;
    hold(0, 5);
    peek(3, 1, "R3 idle count");
    tick(1);
    peek(3, 1, "R2 k");
    peek(3, 1, "R2 k+1");
    peek(3, 1, "R2 k+2");
    peek(3, 2, "R2 k+3");
    peek(3, 3, "R4 step");
    hold(0, 10);
    pulse(10, 10, 1); pulse(10, 10, 1); pulse(10, 10, 1);
    hold(0, 5);
    peek(0, 10, "R5 width");
    peek(1, 20, "R6 period");
    peek(2, 1, "R8 flag set");
    wr_reg(2, 0);
    peek(2, 1, "R11 status bit0 zero");
    wr_reg(0, 77); wr_reg(1, 77); wr_reg(3, 77);
    peek(0, 10, "R11 width write");
    peek(1, 20, "R11 period write");
    wr_reg(2, 1);
    peek(2, 0, "R8 flag clear");

    @(negedge clk) irq_en = 1'b1;
    pulse(10, 10, 1); pulse(4, 12, 1); pulse(6, 10, 1);
    hold(0, 3);
    peek(0, 10, "R9 width sticky");
    peek(1, 16, "R9 period updates");
    wr_reg(2, 1);
    pulse(6, 10, 1);
    peek(0, 6, "R9 width after clear");

    @(negedge clk) irq_en = 1'b0;
    hold(1, 5);
    tick(0); tick(0);
    wr_reg(2, 1);
    peek(2, 1, "R8 capture beats clear");
    peek(0, 5, "R5 width concurrent");

    @(negedge clk) enable = 1'b0;
    hold(1, 3);
    @(negedge clk) begin pol = 1'b0; enable = 1'b1; end
    pulse(7, 13, 0); pulse(7, 13, 0);
    hold(0, 3);
    peek(0, 7, "R7 low width");
    peek(1, 20, "R7 low period");

    @(negedge clk) enable = 1'b0;
    @(negedge clk) begin pol = 1'b1; enable = 1'b1; end
    hold(0, 2);
    hold(1, 300);
    peek(3, MAXV, "R10 saturate");
    peek(2, 3, "R10 overflow set");
    hold(0, 3);
    hold(1, 3);
    peek(1, MAXV, "R10 period at max");
    peek(2, 1, "R10 overflow cleared");
    @(negedge clk) enable = 1'b0;
    hold(1, 2);
    peek(3, 1, "R3 disabled count");
    peek(2, 1, "R3 overflow off");
    finish_run();
  end
endmodule